// File: doc/BRIEF.md
# Random-Threshold Dithering Pixel Expander

The block takes 32-bit words, each carrying four packed framebuffer pixels, and turns every word into a stream of eight colour indices, two for each pixel. Each pixel byte holds a base palette index in its upper bits and a fraction in its lower bits. The block adds a pseudo-random value to the whole byte and keeps the bits above the fraction. The result is the base index or the next index up. The chance of getting the next index rises linearly with the fraction.

A one-bit mode selects one of two byte formats. One has a 4-bit base and a 4-bit fraction. The other has a 2-bit base and a 6-bit fraction. The random values come from an internal 32-bit LFSR. Two draws are made per word, and each draw covers all four byte lanes. Words enter through a valid/ready handshake. The colour indices leave through a valid/ready stream, one index per beat.

Top module: `dither_expander`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, in_ready_o is 1, out_valid_o is 0 and err_o is 0.
- R2: With mode 0 captured, the index for byte lane k is (byte + r) >> 4, where r is bits [8k+3:8k] of the LFSR state used by that draw.
- R3: With mode 1 captured, the index for byte lane k is (byte + r) >> 6, where r is bits [8k+5:8k] of the LFSR state used by that draw. The upper two index bits are then 0.
- R4: The LFSR starts at LFSR_SEED after reset. One step is next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. The first draw of a word uses the current state and the second draw uses the state one step later. The LFSR advances two steps per accepted word and never becomes zero.
- R5: A word yields exactly eight beats in this order: lane 0 first draw, lane 0 second draw, lane 1 first draw, and so on up to lane 3 second draw (lane k is bits [8k+7:8k]).
- R6: In mode 0, a byte above 0xF0 has its lane sum clipped to 0xFF and sets err_o one cycle after acceptance. err_o then stays 1 until reset.
- R7: In mode 1, a lane sum above 0xFF is clipped to 0xFF, giving index 3, and err_o is not set.
- R8: While out_valid_o is 1 and out_ready_i is 0, the beat is held: out_valid_o stays 1 and out_idx_o is unchanged.
- R9: After a word is accepted, in_ready_o is 0 until its last beat is taken, and in_valid_i has no effect during that time.
- R10: The mode is captured when the word is accepted. Changing mode_i while that word's beats are being emitted does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: 4-bit fraction, 1: 6-bit fraction |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Four packed pixel bytes, lane 0 in bits 7:0 |
| in_ready_o | output | 1 | Block can accept a word |
| out_valid_o | output | 1 | Output index valid |
| out_ready_i | input | 1 | Consumer takes the index |
| out_idx_o | output | 4 | Dithered colour index |
| err_o | output | 1 | Sticky mode-0 lane overflow flag |

## Verification
The assertions assume that out_ready_i and mode_i are only sampled at clock edges. They also assume that the consumer may stall without limit, so no assertion requires beats to make progress. The overflow property reads bytes from in_data_i only in a cycle where a word is accepted in mode 0.

The stimulus is applied on the falling clock edge, so every input is settled well before the edge that samples it. Every word is sent in mode 0 with all bytes at or below 0xF0, except for one directed word that deliberately overflows. Mode 1 words cover the full byte range, which exercises saturation without setting the flag.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int LFSR_W = 32;

  typedef enum logic {
    FRAC4 = 1'b0,
    FRAC6 = 1'b1
  } frac_mode_e;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/dith_lfsr.sv
module dith_lfsr
  import dith_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] cur_o,
  output logic [LFSR_W-1:0] nxt_o
);
  logic [LFSR_W-1:0] state_q;

  assign cur_o = state_q;
  assign nxt_o = lfsr_step(state_q);

  // two passes per word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= lfsr_step(nxt_o);
  end
endmodule

// File: rtl/dith_lane.sv
module dith_lane
  import dith_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FR_LO  = 4,
  parameter int FR_HI  = 6,
  parameter int IDX_W  = PIX_W - FR_LO
) (
  input  frac_mode_e         mode_i,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic [FR_HI-1:0]   rnd_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               ovf_o
);
  localparam logic [PIX_W-1:0] LIM_LO = PIX_W'(((1 << (PIX_W - FR_LO)) - 1) << FR_LO);

  logic [FR_HI-1:0] rnd_eff;
  logic [PIX_W:0]   sum;
  logic [PIX_W-1:0] sat;

  always_comb begin
    rnd_eff = (mode_i == FRAC6) ? rnd_i : {{(FR_HI-FR_LO){1'b0}}, rnd_i[FR_LO-1:0]};
    sum     = {1'b0, pix_i} + (PIX_W+1)'(rnd_eff);
    sat     = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];
    if (mode_i == FRAC6) idx_o = IDX_W'(sat[PIX_W-1:FR_HI]);
    else                 idx_o = sat[PIX_W-1:FR_LO];
    ovf_o = (mode_i == FRAC4) && (pix_i > LIM_LO);
  end
endmodule

// File: rtl/dither_expander.sv
module dither_expander
  import dith_pkg::*;
#(
  parameter int                LANES     = 4,
  parameter int                PIX_W     = 8,
  parameter int                FR_LO     = 4,
  parameter int                FR_HI     = 6,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h1D87_2B41,
  parameter int                IDX_W     = PIX_W - FR_LO,
  parameter int                WORD_W    = LANES * PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic              err_o
);
  localparam int NBEAT = 2 * LANES;
  localparam int CNT_W = $clog2(NBEAT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBEAT - 1);

  logic              accept;
  logic              beat_take;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  frac_mode_e        mode_q;
  logic              err_q;
  logic [IDX_W-1:0]  idx_q [NBEAT];
  logic [IDX_W-1:0]  idx_d [NBEAT];
  logic [LANES-1:0]  ovf_a;
  logic [LANES-1:0]  ovf_b;
  logic [LFSR_W-1:0] lfsr_s;
  logic [LFSR_W-1:0] lfsr_n;
  frac_mode_e        mode_in;

  assign mode_in    = frac_mode_e'(mode_i);
  assign in_ready_o = !busy_q;
  assign accept     = in_valid_i && in_ready_o;
  assign out_valid_o = busy_q;
  assign beat_take  = busy_q && out_ready_i;
  assign out_idx_o  = idx_q[cnt_q];
  assign err_o      = err_q;

  dith_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .cur_o (lfsr_s),
    .nxt_o (lfsr_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dith_lane #(.PIX_W(PIX_W), .FR_LO(FR_LO), .FR_HI(FR_HI), .IDX_W(IDX_W)) u_draw_a (
      .mode_i(mode_in),
      .pix_i (in_data_i[g*PIX_W +: PIX_W]),
      .rnd_i (lfsr_s[g*8 +: FR_HI]),
      .idx_o (idx_d[2*g]),
      .ovf_o (ovf_a[g])
    );
    dith_lane #(.PIX_W(PIX_W), .FR_LO(FR_LO), .FR_HI(FR_HI), .IDX_W(IDX_W)) u_draw_b (
      .mode_i(mode_in),
      .pix_i (in_data_i[g*PIX_W +: PIX_W]),
      .rnd_i (lfsr_n[g*8 +: FR_HI]),
      .idx_o (idx_d[2*g+1]),
      .ovf_o (ovf_b[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= FRAC4;
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_in;
        if (|ovf_a) err_q <= 1'b1;
      end else if (beat_take) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < NBEAT; b++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     idx_q[b] <= '0;
      else if (accept) idx_q[b] <= idx_d[b];
    end
  end

  logic unused_ok;
  assign unused_ok = ^ovf_b;
endmodule

// File: rtl/dither_expander_chk.sv
module dither_expander_chk #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic              in_valid_i,
  input logic [WORD_W-1:0] in_data_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [IDX_W-1:0]  out_idx_o,
  input logic              err_o,
  input logic              mode_q,
  input logic [31:0]       lfsr_s
);
  logic big_byte;
  assign big_byte = (in_data_i[7:0] > 8'hF0) || (in_data_i[15:8] > 8'hF0) ||
                    (in_data_i[23:16] > 8'hF0) || (in_data_i[31:24] > 8'hF0);

  a_r8_hold_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_idx_o));

  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && !in_ready_o);

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r6_flag_on_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !mode_i && big_byte |=> err_o);

  a_r7_narrow_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && mode_q |-> out_idx_o <= IDX_W'(3));

  a_r4_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_s != 32'h0);

  a_r10_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(out_valid_o) |-> $stable(mode_q));
endmodule

bind dither_expander dither_expander_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_idx_o  (out_idx_o),
  .err_o      (err_o),
  .mode_q     (mode_q),
  .lfsr_s     (lfsr_s)
);

// File: tb/dither_expander_tb.sv
module dither_expander_tb;
  localparam logic [31:0] SEED = 32'h1D87_2B41;
  localparam int NVEC = 8;
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h00_10_80_F0},
    {1'b0, 32'h37_A8_5F_01},
    {1'b1, 32'h00_3F_40_BF},
    {1'b1, 32'hC0_FF_7E_21},
    {1'b0, 32'h12_34_56_78},
    {1'b1, 32'h80_80_80_80},
    {1'b0, 32'hF0_F0_F0_F0},
    {1'b1, 32'hA5_C3_1E_99}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [3:0]  out_idx_o;
  logic        err_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] st;

  always #10 clk_i = ~clk_i;

  dither_expander u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_idx_o(out_idx_o), .err_o(err_o)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [3:0] model(input logic m, input logic [7:0] px,
                                       input logic [31:0] s, input int lane);
    int sum;
    if (!m) sum = int'(px) + int'(s[8*lane +: 4]);
    else    sum = int'(px) + int'(s[8*lane +: 6]);
    if (sum > 255) sum = 255;
    return m ? 4'(sum >> 6) : 4'(sum >> 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic m, input logic [31:0] d);
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    mode_i = m; in_data_i = d; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // R2 R3 R5: eight beats, lane-major, draw A then B
  task automatic drain(input logic m, input logic [31:0] d, input string req);
    for (int b = 0; b < 8; b++) begin
      chk({req, " R5 valid"}, 32'(out_valid_o), 32'd1);
      chk({req, " R9 ready low"}, 32'(in_ready_o), 32'd0);
      chk(req, 32'(out_idx_o),
          32'(model(m, d[8*(b/2) +: 8], (b % 2 == 1) ? step(st) : st, b / 2)));
      @(negedge clk_i);
    end
    st = step(step(st));
    chk({req, " R5 end"}, 32'(out_valid_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    st = SEED;
    repeat (2) @(negedge clk_i);
    chk("R1 ready in reset", 32'(in_ready_o), 32'd1);
    chk("R1 valid in reset", 32'(out_valid_o), 32'd0);
    chk("R1 err in reset", 32'(err_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after", 32'(in_ready_o), 32'd1);
    chk("R1 valid after", 32'(out_valid_o), 32'd0);

    // table walk: R2 (mode 0), R3 (mode 1), R4 draws, R7 saturation
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][32], VEC[i][31:0]);
      drain(VEC[i][32], VEC[i][31:0], VEC[i][32] ? "R3 R4" : "R2 R4");
    end
    chk("R7 no flag in mode 1", 32'(err_o), 32'd0);

    // R8: stall
    out_ready_i = 1'b0;
    send(1'b0, 32'h6C_2B_E0_47);
    begin
      logic [3:0] held;
      held = out_idx_o;
      repeat (3) @(negedge clk_i);
      chk("R8 held valid", 32'(out_valid_o), 32'd1);
      chk("R8 held idx", 32'(out_idx_o), 32'(held));
    end
    out_ready_i = 1'b1;
    drain(1'b0, 32'h6C_2B_E0_47, "R8 R2");

    // R9: junk offered while busy; R10: mode flipped mid-word
    send(1'b1, 32'h3D_E2_91_7F);
    mode_i = 1'b0;
    in_data_i = 32'hFF_FF_FF_FF;
    in_valid_i = 1'b1;
    drain(1'b1, 32'h3D_E2_91_7F, "R9 R10");
    in_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R9 junk ignored", 32'(out_valid_o), 32'd0);
    chk("R9 err untouched", 32'(err_o), 32'd0);

    // R6: mode 0 overflow, clipped, sticky flag
    send(1'b0, 32'h00_FF_F5_F1);
    chk("R6 flag set", 32'(err_o), 32'd1);
    drain(1'b0, 32'h00_FF_F5_F1, "R6 clip");
    send(1'b0, 32'h10_20_30_40);
    drain(1'b0, 32'h10_20_30_40, "R6 R2");
    chk("R6 flag sticky", 32'(err_o), 32'd1);

    // R1 R4: reset clears flag and reseeds
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 err cleared", 32'(err_o), 32'd0);
    rst_ni = 1'b1;
    st = SEED;
    send(1'b0, 32'h8F_0C_77_A3);
    drain(1'b0, 32'h8F_0C_77_A3, "R4 reseed");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule